// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Narrow Line Fill

This block is a read-only instruction cache that sits between a fetch unit and an external memory port. The fetch unit presents a physical byte address and receives the aligned 32-bit word that contains it. When the word is resident, the word comes back in the same cycle as the request. It holds 8 KB as 512 direct-mapped lines of 16 bytes. Each line carries one tag and one valid flag.

On a miss, the fetch stalls. The cache then asks the external port for the whole line, starting at its base address. The port may be 8, 16 or 32 bits wide, set by a parameter. The cache builds the 16-byte line from the narrow beats and writes the line with its tag once the last beat arrives. After that, the waiting fetch is served from the array. A beat marked as an error abandons the fill, leaves the line invalid and sends an error response to the fetch unit. A flush input clears every valid flag at once.

Top module: `icache_narrow_fill`

## Requirements
- R1: Out of reset no line is valid and all outputs are low. The first fetch to any address misses and starts a fill.
- R2: A fetch to a resident line raises fetchValid in the same cycle as fetchReq, with the word on fetchData, and issues no fill.
- R3: The address splits into offset [3:0], index [12:4] and tag [31:13]. fetchData is the little-endian word at byte offset {fetchAddr[3:2],2'b00} within the line, and fetchAddr[1:0] has no effect. Two addresses with equal index and different tag evict one another.
- R4: On a miss, memReq rises in the next cycle. memAddr holds the line base (low 4 bits zero) and stays stable until the fill ends.
- R5: A fill takes 128/PORT_W beats. Beat k carries the bytes at memAddr + k*PORT_W/8 onward, with the lowest address in the lowest bits of memBeatData.
- R6: fetchValid stays low during a fill. The line becomes valid only at the edge that accepts the last beat, so a gap-free miss is served PORT-dependent 128/PORT_W + 2 cycles after the request.
- R7: A beat is accepted only in a cycle with memBeatValid high. Idle cycles between beats lengthen the fill but do not change the assembled line.
- R8: A beat with memBeatErr high ends the fill. memReq drops, fetchErr is high for exactly one cycle in the following cycle, and the line stays invalid, so the next fetch to it misses again.
- R9: invalidateAll, raised while no fill runs, clears every valid flag in one cycle. A fetch presented in that same cycle is not served. invalidateAll must not be raised during a fill.
- R10: The same behaviour holds for PORT_W values of 8, 16 and 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| invalidateAll | input | 1 | Clear all valid flags |
| fetchReq | input | 1 | Fetch request, held until fetchValid or fetchErr |
| fetchAddr | input | ADDR_W | Physical byte address of the fetch |
| fetchValid | output | 1 | fetchData holds the requested word |
| fetchErr | output | 1 | The fill for this fetch failed |
| fetchData | output | 32 | Instruction word |
| memReq | output | 1 | Line fill in progress |
| memAddr | output | ADDR_W | Base address of the line being filled |
| memBeatValid | input | 1 | A beat is present on memBeatData |
| memBeatData | input | PORT_W | Beat payload |
| memBeatErr | input | 1 | The present beat is faulty |

## Verification
The hardest situation to reach is a fault that arrives on the final beat of a fill. The line buffer is then fully populated, and a single wrong gate would commit it as valid. The bench's memory responder can inject an error at a chosen beat index. It fails both the last beat and the first beat of separate fills, and then refetches the first line to show that it still misses. Eviction between aliasing tags and flushes are reached by fetching addresses 8 KB apart and by raising the flush together with a fetch to a line known to be resident.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_ERR  = 2'd2
  } fillState_t;

  typedef struct packed {
    logic latchMiss;
    logic beatWr;
    logic lineWr;
    logic clearAll;
  } ctrlStrobe_t;

endpackage

// File: rtl/icache_dp.sv
module icache_dp
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 512,
  parameter int PORT_W     = 8,
  parameter int WORD_W     = 32,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int IDX_W     = $clog2(NUM_LINES),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W    = LINE_BYTES * 8,
  localparam int BEATS     = LINE_W / PORT_W,
  localparam int BEAT_W    = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int WORDS     = LINE_W / WORD_W,
  localparam int WSEL_W    = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobe,
  input  logic [BEAT_W-1:0]         beatIdx,
  input  logic [ADDR_W-OFF_W-1:0]   fetchLine,
  input  logic [WSEL_W-1:0]         fetchWord,
  input  logic [PORT_W-1:0]         memBeatData,
  output logic                      hit,
  output logic [WORD_W-1:0]         fetchData,
  output logic [ADDR_W-1:0]         memAddr
);

  logic [LINE_W-1:0]      dataArr [NUM_LINES];
  logic [TAG_W-1:0]       tagArr  [NUM_LINES];
  logic [NUM_LINES-1:0]   validVec;
  logic [LINE_W-1:0]      fillBuf;
  logic [LINE_W-1:0]      lineNext;
  logic [ADDR_W-OFF_W-1:0] missLine;

  logic [IDX_W-1:0] rdIdx;
  logic [TAG_W-1:0] rdTag;
  logic [IDX_W-1:0] wrIdx;
  logic [TAG_W-1:0] wrTag;
  logic [LINE_W-1:0] rdLine;

  assign rdIdx = fetchLine[IDX_W-1:0];
  assign rdTag = fetchLine[ADDR_W-OFF_W-1:IDX_W];
  assign wrIdx = missLine[IDX_W-1:0];
  assign wrTag = missLine[ADDR_W-OFF_W-1:IDX_W];

  // Merge the beat on the bus into its slot of the line buffer.
  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    assign lineNext[b*PORT_W +: PORT_W] =
      (strobe.beatWr && (beatIdx == BEAT_W'(b))) ? memBeatData
                                                 : fillBuf[b*PORT_W +: PORT_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillBuf  <= '0;
      missLine <= '0;
    end else begin
      if (strobe.latchMiss) missLine <= fetchLine;
      if (strobe.beatWr)    fillBuf  <= lineNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validVec <= '0;
    end else if (strobe.clearAll) begin
      validVec <= '0;
    end else if (strobe.lineWr) begin
      validVec[wrIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.lineWr) begin
      dataArr[wrIdx] <= lineNext;
      tagArr[wrIdx]  <= wrTag;
    end
  end

  assign rdLine    = dataArr[rdIdx];
  assign hit       = validVec[rdIdx] && (tagArr[rdIdx] == rdTag);
  assign fetchData = rdLine[fetchWord*WORD_W +: WORD_W];
  assign memAddr   = {missLine, {OFF_W{1'b0}}};

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int BEATS  = 16,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic              hit,
  input  logic              invalidateAll,
  input  logic              memBeatValid,
  input  logic              memBeatErr,
  output ctrlStrobe_t       strobe,
  output logic [BEAT_W-1:0] beatIdx,
  output logic              memReq,
  output logic              fetchValid,
  output logic              fetchErr
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  fillState_t        state, stateNext;
  logic [BEAT_W-1:0] beatCnt, beatNext;

  always_comb begin
    strobe     = '0;
    memReq     = 1'b0;
    fetchValid = 1'b0;
    fetchErr   = 1'b0;
    stateNext  = state;
    beatNext   = beatCnt;
    unique case (state)
      ST_IDLE: begin
        if (invalidateAll) begin
          strobe.clearAll = 1'b1;
        end else if (fetchReq) begin
          if (hit) begin
            fetchValid = 1'b1;
          end else begin
            strobe.latchMiss = 1'b1;
            beatNext         = '0;
            stateNext        = ST_FILL;
          end
        end
      end
      ST_FILL: begin
        memReq = 1'b1;
        if (memBeatValid) begin
          if (memBeatErr) begin
            stateNext = ST_ERR;
          end else begin
            strobe.beatWr = 1'b1;
            if (beatCnt == LAST_BEAT) begin
              strobe.lineWr = 1'b1;
              stateNext     = ST_IDLE;
            end else begin
              beatNext = beatCnt + 1'b1;
            end
          end
        end
      end
      ST_ERR: begin
        fetchErr  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      beatCnt <= '0;
    end else begin
      state   <= stateNext;
      beatCnt <= beatNext;
    end
  end

  assign beatIdx = beatCnt;

endmodule

// File: rtl/icache_narrow_fill.sv
module icache_narrow_fill
  import icache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int NUM_LINES  = 512,
  parameter int PORT_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              invalidateAll,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchValid,
  output logic              fetchErr,
  output logic [31:0]       fetchData,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memBeatValid,
  input  logic [PORT_W-1:0] memBeatData,
  input  logic              memBeatErr
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int BEATS  = LINE_BYTES * 8 / PORT_W;
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;

  ctrlStrobe_t       strobe;
  logic [BEAT_W-1:0] beatIdx;
  logic              hit;

  icache_ctrl #(.BEATS(BEATS)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .fetchReq     (fetchReq),
    .hit          (hit),
    .invalidateAll(invalidateAll),
    .memBeatValid (memBeatValid),
    .memBeatErr   (memBeatErr),
    .strobe       (strobe),
    .beatIdx      (beatIdx),
    .memReq       (memReq),
    .fetchValid   (fetchValid),
    .fetchErr     (fetchErr)
  );

  icache_dp #(
    .ADDR_W    (ADDR_W),
    .LINE_BYTES(LINE_BYTES),
    .NUM_LINES (NUM_LINES),
    .PORT_W    (PORT_W),
    .WORD_W    (32)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .beatIdx    (beatIdx),
    .fetchLine  (fetchAddr[ADDR_W-1:OFF_W]),
    .fetchWord  (fetchAddr[OFF_W-1:2]),
    .memBeatData(memBeatData),
    .hit        (hit),
    .fetchData  (fetchData),
    .memAddr    (memAddr)
  );

endmodule

// File: rtl/icache_chk.sv
module icache_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int PORT_W     = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              invalidateAll,
  input logic              fetchReq,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              fetchValid,
  input logic              fetchErr,
  input logic [31:0]       fetchData,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memBeatValid,
  input logic [PORT_W-1:0] memBeatData,
  input logic              memBeatErr
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int BEATS = LINE_BYTES * 8 / PORT_W;

  int beatSeen;

  always_ff @(posedge clk) begin
    if (!rstN || !memReq) beatSeen <= 0;
    else if (memBeatValid && !memBeatErr) beatSeen <= beatSeen + 1;
  end

  AST_VALID_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid |-> (fetchReq && !invalidateAll)); // R2
  AST_FILL_START_FROM_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> $past(fetchReq)); // R1
  AST_NO_VALID_IN_FILL: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !fetchValid); // R6
  AST_FILL_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[OFF_W-1:0] == '0)); // R4
  AST_FILL_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && $past(memReq)) |-> $stable(memAddr)); // R4
  AST_FILL_TARGETS_MISS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReq) |-> (memAddr[ADDR_W-1:OFF_W] == $past(fetchAddr[ADDR_W-1:OFF_W]))); // R4
  AST_BEAT_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memReq) && !fetchErr) |-> (beatSeen == BEATS)); // R5
  AST_ERR_AFTER_BAD_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    fetchErr |-> $past(memReq && memBeatValid && memBeatErr)); // R8
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    fetchErr |=> !fetchErr); // R8
  AST_NO_FLUSH_IN_FILL: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> !invalidateAll); // R9

endmodule

bind icache_narrow_fill icache_chk #(
  .ADDR_W    (ADDR_W),
  .LINE_BYTES(LINE_BYTES),
  .PORT_W    (PORT_W)
) u_chk (.*);

// File: tb/icache_narrow_fill_tb.sv
`timescale 1ns/1ps
module icache_narrow_fill_tb;

  logic clk  = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  end

  function automatic logic [7:0] byteOf(input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[20:13] ^ a[15:8];
  endfunction

  function automatic logic [31:0] wordOf(input logic [31:0] a);
    logic [31:0] b;
    b = {a[31:2], 2'b00};
    return {byteOf(b + 3), byteOf(b + 2), byteOf(b + 1), byteOf(b)};
  endfunction

  for (genvar L = 0; L < 3; L++) begin : g_lane
    localparam int PW = 8 << L;
    localparam int PB = PW / 8;
    localparam int NB = 16 / PB;

    logic req = 1'b0, inv = 1'b0;
    logic [31:0] addr = '0;
    logic fv, fe, mreq;
    logic [31:0] fd, maddr;
    logic mv = 1'b0, me = 1'b0;
    logic [PW-1:0] md = '0;
    int rb = 0, tick = 0, errBeat = -1;
    bit gapEn = 1'b0;
    int nChk = 0, nFail = 0;
    bit done = 1'b0;

    icache_narrow_fill #(.PORT_W(PW)) u_dut (
      .clk(clk), .rstN(rstN), .invalidateAll(inv),
      .fetchReq(req), .fetchAddr(addr),
      .fetchValid(fv), .fetchErr(fe), .fetchData(fd),
      .memReq(mreq), .memAddr(maddr),
      .memBeatValid(mv), .memBeatData(md), .memBeatErr(me)
    );

    // Burst responder: beats in increasing address order from the line base.
    always @(posedge clk) begin
      int nIdx;
      logic [PW-1:0] t;
      nIdx = rb + ((mreq && mv) ? 1 : 0);
      if (!mreq || nIdx >= NB || (mv && me)) begin
        mv <= 1'b0;
        me <= 1'b0;
        rb <= mreq ? nIdx : 0;
      end else begin
        rb   <= nIdx;
        tick <= tick + 1;
        if (gapEn && tick[0]) begin
          mv <= 1'b0;
        end else begin
          for (int i = 0; i < PB; i++) t[i*8 +: 8] = byteOf(maddr + nIdx * PB + i);
          mv <= 1'b1;
          md <= t;
          me <= (nIdx == errBeat);
        end
      end
    end

    task automatic chk(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
      nChk++;
      if (!ok) begin
        nFail++;
        $display("FAIL %s pw=%0d act=%h exp=%h", what, PW, act, exp);
      end
    endtask

    task automatic fetch(input logic [31:0] a, output int lat,
                         output bit err, output logic [31:0] d);
      @(negedge clk);
      req  = 1'b1;
      addr = a;
      lat  = 0;
      forever begin
        #1;
        if (fv || fe || lat > 400) break;
        @(negedge clk);
        lat++;
      end
      d   = fd;
      err = fe;
      @(negedge clk);
      req = 1'b0;
    endtask

    task automatic expectFetch(input logic [31:0] a, input int expLat,
                               input string tag);
      int lat; bit err; logic [31:0] d;
      fetch(a, lat, err, d);
      chk(!err, {tag, " no error"}, 32'(err), 0);
      chk(lat == expLat, {tag, " latency"}, lat, expLat);
      chk(d == wordOf(a), {tag, " data"}, d, wordOf(a));
    endtask

    initial begin
      int lat; bit err; logic [31:0] d;
      wait (rstN);
      @(negedge clk);
      chk(!fv && !fe && !mreq, "R1 reset outputs", {fv, fe, mreq}, 0);

      // R1 R4 R5 R6 R10: every line misses once, word and byte offset varied.
      for (int i = 0; i < 512; i++)
        expectFetch(i * 16 + (i % 4) * 4 + (i % 4), NB + 2, "R1 R4 R5 R6 R10 miss sweep");
      // R2 R3: second pass hits in the request cycle on another word.
      for (int i = 0; i < 512; i++)
        expectFetch(i * 16 + ((i + 1) % 4) * 4 + 3, 0, "R2 R3 hit sweep");

      // R3: aliasing tags 8 KB apart evict each other.
      expectFetch(32'h0000_0044, 0,      "R3 resident before alias");
      expectFetch(32'h0000_2044, NB + 2, "R3 alias miss");
      expectFetch(32'h0000_0048, NB + 2, "R3 evicted line refilled");

      // R7: gaps between beats.
      gapEn = 1'b1;
      fetch(32'h0001_0108, lat, err, d);
      chk(lat > NB + 2 || NB == 1, "R7 gapped fill longer", lat, NB + 2);
      chk(d == wordOf(32'h0001_0108) && !err, "R7 gapped data", d, wordOf(32'h0001_0108));
      gapEn = 1'b0;
      expectFetch(32'h0001_010C, 0, "R7 gapped line resident");

      // R8: error on the last beat, then on the first beat.
      errBeat = NB - 1;
      fetch(32'h0002_0300, lat, err, d);
      chk(err, "R8 error on last beat", 32'(err), 1);
      chk(lat == NB + 2, "R8 error latency last", lat, NB + 2);
      errBeat = 0;
      fetch(32'h0002_0310, lat, err, d);
      chk(err, "R8 error on first beat", 32'(err), 1);
      chk(lat == 3, "R8 error latency first", lat, 3);
      @(negedge clk);
      chk(!fe, "R8 error lasts one cycle", 32'(fe), 0);
      errBeat = -1;
      expectFetch(32'h0002_0304, NB + 2, "R8 failed line still invalid");
      expectFetch(32'h0002_0314, NB + 2, "R8 failed line refilled");

      // R9: flush with a resident-line fetch in the same cycle.
      @(negedge clk);
      inv = 1'b1; req = 1'b1; addr = 32'h0000_0048;
      #1;
      chk(!fv, "R9 fetch ignored during flush", 32'(fv), 0);
      @(negedge clk);
      inv = 1'b0; req = 1'b0;
      expectFetch(32'h0000_0048, NB + 2, "R9 flushed line misses");
      expectFetch(32'h0000_1000, NB + 2, "R9 other flushed line misses");
      expectFetch(32'h0000_1004, 0,      "R9 refilled line hits");
      done = 1'b1;
    end
  end

  initial begin
    int cyc = 0;
    int totChk, totFail;
    while (!(g_lane[0].done && g_lane[1].done && g_lane[2].done) && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    totChk  = g_lane[0].nChk + g_lane[1].nChk + g_lane[2].nChk;
    totFail = g_lane[0].nFail + g_lane[1].nFail + g_lane[2].nFail;
    if (!(g_lane[0].done && g_lane[1].done && g_lane[2].done)) begin
      totChk++;
      totFail++;
      $display("FAIL watchdog R1 act=%0d exp=done", cyc);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", totChk, totFail);
    $finish;
  end

endmodule